// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

An iterative arithmetic unit for the eight integer multiply and divide operations of a 32-bit RISC-V core. The issuing stage presents an operation code and two operands and pulses a start strobe. It then stalls until the unit raises a one-cycle done flag alongside the result.

A single 64-bit accumulator serves both algorithms. Multiplication adds the multiplicand into the upper half when the low bit of the shifting multiplier is set, then shifts right. Division uses restoring steps: it shifts left, makes a trial subtraction of the divisor, and keeps the difference only when it is not negative. Signed operations run on operand magnitudes. A final fix-up cycle restores the signs and selects the low half, the high half, the quotient or the remainder. The parameter `UNROLL` (1, 2 or 4) sets how many steps are chained in each clock. A kill input abandons an operation in flight.

Top module: `muldiv_seq`

## Requirements
- R1: Operation codes are 0 mul, 1 mulh, 2 mulhsu, 3 mulhu, 4 div, 5 divu, 6 rem, 7 remu. For mul, the result is the low 32 bits of the product.
- R2: mulh, mulhsu and mulhu return the upper 32 bits of the 64-bit product. mulh treats both operands as signed. mulhsu treats `op_a` as signed and `op_b` as unsigned. mulhu treats both as unsigned.
- R3: div and divu return the quotient truncated toward zero. div is signed and divu is unsigned.
- R4: rem and remu return the remainder. For rem, the remainder carries the sign of the dividend.
- R5: When the divisor is zero, the quotient is all ones and the remainder equals the dividend.
- R6: Signed division of 0x80000000 by 0xFFFFFFFF returns 0x80000000 as the quotient and 0 as the remainder.
- R7: `res_done` rises exactly 32/UNROLL + 1 clock edges after the edge that accepts `op_start`. It stays high for one cycle.
- R8: `op_start` is ignored while `busy` is high. The operation in flight completes with its own operands, and only one done pulse results.
- R9: `op_kill` returns the unit to idle on the next edge. No done pulse follows, and a new operation can start afterwards.
- R10: After reset, `busy` and `res_done` are 0 and `res_value` is 0. `res_value` changes only in a cycle where `res_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Start strobe, accepted only when idle |
| op_code | input | 3 | Operation select (see R1) |
| op_a | input | 32 | Multiplicand or dividend |
| op_b | input | 32 | Multiplier or divisor |
| op_kill | input | 1 | Abort the operation in flight |
| busy | output | 1 | Operation in progress; the issuing stage stalls on this |
| res_done | output | 1 | One-cycle pulse: result valid |
| res_value | output | 32 | Result, held until the next completion |

## Verification
The operand table pairs small positive values with negative and extreme ones. This separates sign handling from magnitude handling. The same operand pair is tried under different high-half variants, which exposes any mix-up of signed and unsigned treatment. Division vectors include a negative dividend with a positive divisor and the reverse case. Together these distinguish truncation toward zero and a remainder that takes the dividend's sign from the floor-style alternatives. Zero divisors and the most-negative-over-minus-one case test the override paths. Directed runs measure the latency edge by edge, inject a start while busy, and kill an operation part way through.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int MD_XW = 32;
  localparam int MD_AW = 2 * MD_XW;

  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } md_op_e;

  function automatic logic md_is_div(input md_op_e op);
    return op[2];
  endfunction

  function automatic logic md_a_signed(input md_op_e op);
    return (op == OP_MULH) || (op == OP_MULHSU) || (op == OP_DIV) || (op == OP_REM);
  endfunction

  function automatic logic md_b_signed(input md_op_e op);
    return (op == OP_MULH) || (op == OP_DIV) || (op == OP_REM);
  endfunction

  // One iteration: restoring divide step or shift-add multiply step.
  function automatic logic [MD_AW-1:0] md_step(input logic [MD_AW-1:0] acc,
                                                input logic [MD_XW-1:0] opnd,
                                                input logic is_div);
    logic [MD_XW:0]   hi_ext;
    logic [MD_XW+1:0] diff;
    logic [MD_XW:0]   sum;
    logic [MD_AW-1:0] nxt;
    if (is_div) begin
      hi_ext = acc[MD_AW-1:MD_XW-1];
      diff   = {1'b0, hi_ext} - {2'b00, opnd};
      nxt    = {acc[MD_AW-2:0], 1'b0};
      if (!diff[MD_XW+1]) begin
        nxt[MD_AW-1:MD_XW] = diff[MD_XW-1:0];
        nxt[0]             = 1'b1;
      end
    end else begin
      sum = {1'b0, acc[MD_AW-1:MD_XW]} + (acc[0] ? {1'b0, opnd} : '0);
      nxt = {sum, acc[MD_XW-1:1]};
    end
    return nxt;
  endfunction

  // Final sign correction and half / quotient / remainder selection.
  function automatic logic [MD_XW-1:0] md_fix(input md_op_e op,
                                               input logic [MD_AW-1:0] acc,
                                               input logic neg_main,
                                               input logic neg_rem,
                                               input logic b_zero);
    logic [MD_AW-1:0] prod;
    logic [MD_XW-1:0] quo, rmd;
    prod = neg_main ? -acc : acc;
    quo  = acc[MD_XW-1:0];
    rmd  = acc[MD_AW-1:MD_XW];
    case (op)
      OP_MUL:                       return prod[MD_XW-1:0];
      OP_MULH, OP_MULHSU, OP_MULHU: return prod[MD_AW-1:MD_XW];
      OP_DIV, OP_DIVU:              return b_zero ? '1 : (neg_main ? -quo : quo);
      default:                      return neg_rem ? -rmd : rmd;
    endcase
  endfunction
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
  parameter int ITER = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic kill,
  output logic accept,
  output logic step_en,
  output logic fix_en,
  output logic last_iter,
  output logic busy
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;

  typedef enum logic [1:0] { ST_IDLE, ST_RUN, ST_FIX } st_e;
  st_e           st_q;
  logic [CW-1:0] cnt_q;

  assign accept    = (st_q == ST_IDLE) && start && !kill;
  assign step_en   = (st_q == ST_RUN) && !kill;
  assign fix_en    = (st_q == ST_FIX) && !kill;
  assign last_iter = step_en && (cnt_q == CW'(ITER - 1));
  assign busy      = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (kill) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q  <= ST_RUN;
          cnt_q <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_iter) st_q <= ST_FIX;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_core.sv
module muldiv_core
  import muldiv_pkg::*;
#(
  parameter int UNROLL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step_en,
  input  logic [2:0]       op_in,
  input  logic [MD_XW-1:0] a_in,
  input  logic [MD_XW-1:0] b_in,
  output logic [MD_AW-1:0] acc_o,
  output md_op_e           op_o,
  output logic             neg_main_o,
  output logic             neg_rem_o,
  output logic             b_zero_o
);
  md_op_e           op_new;
  logic             a_neg, b_neg;
  logic [MD_XW-1:0] a_mag, b_mag;
  logic [MD_AW-1:0] acc_q;
  logic [MD_XW-1:0] opnd_q;
  logic [MD_AW-1:0] chain [UNROLL+1];

  assign op_new = md_op_e'(op_in);
  assign a_neg  = md_a_signed(op_new) && a_in[MD_XW-1];
  assign b_neg  = md_b_signed(op_new) && b_in[MD_XW-1];
  assign a_mag  = a_neg ? -a_in : a_in;
  assign b_mag  = b_neg ? -b_in : b_in;

  assign chain[0] = acc_q;
  for (genvar g = 0; g < UNROLL; g++) begin : g_unroll
    assign chain[g+1] = md_step(chain[g], opnd_q, md_is_div(op_o));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      opnd_q     <= '0;
      op_o       <= OP_MUL;
      neg_main_o <= 1'b0;
      neg_rem_o  <= 1'b0;
      b_zero_o   <= 1'b0;
    end else if (load) begin
      op_o       <= op_new;
      neg_main_o <= a_neg ^ b_neg;
      neg_rem_o  <= a_neg;
      b_zero_o   <= (b_in == '0);
      if (md_is_div(op_new)) begin
        acc_q  <= {{MD_XW{1'b0}}, a_mag};
        opnd_q <= b_mag;
      end else begin
        acc_q  <= {{MD_XW{1'b0}}, b_mag};
        opnd_q <= a_mag;
      end
    end else if (step_en) begin
      acc_q <= chain[UNROLL];
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int UNROLL = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_start,
  input  logic [2:0]  op_code,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        op_kill,
  output logic        busy,
  output logic        res_done,
  output logic [31:0] res_value
);
  localparam int ITER = MD_XW / UNROLL;

  logic             ev_accept, ev_step, ev_finish, ev_last_iter;
  logic [MD_AW-1:0] acc;
  md_op_e           op_q;
  logic             neg_main, neg_rem, b_zero;
  logic             done_q;
  logic [MD_XW-1:0] res_q;

  muldiv_ctrl #(.ITER(ITER)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(op_start), .kill(op_kill),
    .accept(ev_accept), .step_en(ev_step), .fix_en(ev_finish),
    .last_iter(ev_last_iter), .busy(busy)
  );

  muldiv_core #(.UNROLL(UNROLL)) u_core (
    .clk(clk), .rst_n(rst_n), .load(ev_accept), .step_en(ev_step),
    .op_in(op_code), .a_in(op_a), .b_in(op_b),
    .acc_o(acc), .op_o(op_q), .neg_main_o(neg_main),
    .neg_rem_o(neg_rem), .b_zero_o(b_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= ev_finish;
      if (ev_finish) res_q <= md_fix(op_q, acc, neg_main, neg_rem, b_zero);
    end
  end

  assign res_done  = done_q;
  assign res_value = res_q;
endmodule

// File: rtl/muldiv_seq_sva.sv
module muldiv_seq_sva #(
  parameter int UNROLL = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_kill,
  input logic        busy,
  input logic        res_done,
  input logic [31:0] res_value,
  input logic        ev_accept,
  input logic        ev_finish
);
  localparam int ITER = 32 / UNROLL;
  logic [7:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat_cnt <= '0;
    else if (ev_accept) lat_cnt <= '0;
    else if (busy)      lat_cnt <= lat_cnt + 1'b1;
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (lat_cnt == 8'(ITER + 1)));
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);
  a_r8_done_from_fix: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> $past(ev_finish));
  a_r9_kill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    op_kill |=> (!busy && !res_done));
  a_r10_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_value) |-> res_done);
endmodule

bind muldiv_seq muldiv_seq_sva #(.UNROLL(UNROLL)) u_sva (
  .clk(clk), .rst_n(rst_n), .op_kill(op_kill), .busy(busy),
  .res_done(res_done), .res_value(res_value),
  .ev_accept(ev_accept), .ev_finish(ev_finish)
);

// File: tb/muldiv_seq_tb.sv
`timescale 1ns/1ps
module muldiv_seq_tb;
  localparam int UNROLL = 1;
  localparam int LAT    = 32 / UNROLL + 1;
  localparam int NVEC   = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        op_kill = 1'b0;
  logic        busy, res_done;
  logic [31:0] res_value;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  muldiv_seq #(.UNROLL(UNROLL)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .op_kill(op_kill),
    .busy(busy), .res_done(res_done), .res_value(res_value)
  );

  // {req tag, op, a, b, expected}
  localparam logic [102:0] VEC [NVEC] = '{
    {4'd1, 3'd0, 32'd7,         32'd6,         32'h0000002A}, // R1 small mul
    {4'd1, 3'd0, 32'hFFFFFFFD,  32'd5,         32'hFFFFFFF1}, // R1 negative mul
    {4'd2, 3'd1, 32'hFFFFFFFD,  32'd5,         32'hFFFFFFFF}, // R2 mulh sign
    {4'd2, 3'd3, 32'hFFFFFFFF,  32'hFFFFFFFF,  32'hFFFFFFFE}, // R2 mulhu max
    {4'd2, 3'd2, 32'hFFFFFFFF,  32'hFFFFFFFF,  32'hFFFFFFFF}, // R2 mulhsu
    {4'd2, 3'd1, 32'hFFFFFFFF,  32'hFFFFFFFF,  32'h00000000}, // R2 mulh -1*-1
    {4'd2, 3'd1, 32'h80000000,  32'h80000000,  32'h40000000}, // R2 mulh min*min
    {4'd2, 3'd3, 32'h80000000,  32'd2,         32'h00000001}, // R2 mulhu carry
    {4'd3, 3'd4, 32'hFFFFFFF9,  32'd2,         32'hFFFFFFFD}, // R3 -7/2
    {4'd3, 3'd5, 32'd100,       32'd7,         32'd14},       // R3 divu
    {4'd3, 3'd5, 32'hFFFFFFF9,  32'd2,         32'h7FFFFFFC}, // R3 divu large
    {4'd4, 3'd6, 32'hFFFFFFF9,  32'd2,         32'hFFFFFFFF}, // R4 -7%2
    {4'd4, 3'd6, 32'd7,         32'hFFFFFFFE,  32'd1},        // R4 7%-2
    {4'd4, 3'd7, 32'd100,       32'd7,         32'd2},        // R4 remu
    {4'd5, 3'd4, 32'd5,         32'd0,         32'hFFFFFFFF}, // R5 div by 0
    {4'd5, 3'd6, 32'hFFFFFFF9,  32'd0,         32'hFFFFFFF9}, // R5 rem by 0
    {4'd6, 3'd4, 32'h80000000,  32'hFFFFFFFF,  32'h80000000}, // R6 quotient
    {4'd6, 3'd6, 32'h80000000,  32'hFFFFFFFF,  32'h00000000}  // R6 remainder
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Issue one op; returns result and number of edges after the accepting edge.
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] res, output int lat);
    @(negedge clk);
    op_code = op; op_a = a; op_b = b; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    lat = 1;
    while (lat < 200) begin
      @(posedge clk); #1;
      if (res_done) break;
      lat++;
    end
    res = res_value;
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] r;
    int          lat;
    int          dones;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy after reset", {31'b0, busy}, 32'd0);
    check("R10 done after reset", {31'b0, res_done}, 32'd0);
    check("R10 value after reset", res_value, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][98:96], VEC[i][95:64], VEC[i][63:32], r, lat);
      check($sformatf("R%0d vector %0d", VEC[i][102:99], i), r, VEC[i][31:0]);
    end

    // R7 latency and single-cycle done
    run_op(3'd0, 32'd3, 32'd4, r, lat);
    check("R7 latency", 32'(lat), 32'(LAT));
    @(posedge clk); #1;
    check("R7 done one cycle", {31'b0, res_done}, 32'd0);
    check("R10 value held", res_value, 32'd12);

    // R8 start while busy ignored
    @(negedge clk);
    op_code = 3'd5; op_a = 32'd50; op_b = 32'd5; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    repeat (4) @(negedge clk);
    op_code = 3'd0; op_a = 32'd9; op_b = 32'd9; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    dones = 0;
    for (int k = 0; k < LAT + 10; k++) begin
      @(posedge clk); #1;
      if (res_done) begin
        dones++;
        check("R8 in-flight result kept", res_value, 32'd10);
      end
    end
    check("R8 single done pulse", 32'(dones), 32'd1);

    // R9 kill mid-run
    @(negedge clk);
    op_code = 3'd4; op_a = 32'd77; op_b = 32'd7; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    repeat (5) @(negedge clk);
    op_kill = 1'b1;
    @(negedge clk);
    op_kill = 1'b0;
    check("R9 idle after kill", {31'b0, busy}, 32'd0);
    dones = 0;
    for (int k = 0; k < LAT + 5; k++) begin
      @(posedge clk); #1;
      if (res_done) dones++;
    end
    check("R9 no done after kill", 32'(dones), 32'd0);
    run_op(3'd7, 32'd77, 32'd10, r, lat);
    check("R9 restart after kill", r, 32'd7);

    report();
  end
endmodule